// File: doc/BRIEF.md
# Global Register Read-Write Hazard Stall Unit

Two wavefronts, one of even parity and one of odd parity, can issue in the same instruction group on one SIMD. Each one presents up to `NRD` register reads and one register write. These addresses are already translated to physical rows and each carries a region tag. Rows in the global shared region are a single physical copy that both wavefronts see. A write to such a row only becomes visible once a whole instruction period has elapsed. A clause-temporary row has a separate copy for each parity, and a private row belongs to one wavefront only, so neither of these can conflict.

On each cycle the unit looks for a global row that one slot reads while the other slot writes it. When it finds one, it stalls the reading slot and grants the other slot. The stall lasts for `HOLD_CYC` cycles, which is one instruction period. After that the held slot is reissued once without any hazard check against the write it waited for. If each slot reads a row that the other writes, the odd slot is held.

The unit is a five-state controller:
- `ST_ISSUE` is the normal state.
- `ST_HOLD_EV` and `ST_HOLD_OD` hold the even slot or the odd slot.
- `ST_REISS_EV` and `ST_REISS_OD` are the reissue cycles.

Transitions:
- `ST_ISSUE` or a reissue state goes to a hold state on a hazard, or straight to the matching reissue state when `HOLD_CYC` is 1.
- A hold state goes to its reissue state when its counter expires.
- A reissue state goes back to `ST_ISSUE` when no new hazard appears.

Top module: `glreg_hazard_unit`

## Requirements
- R1: While `rst_n` is low, all stall and grant outputs are 0. The first cycle after reset is in `ST_ISSUE`, and there each grant equals its slot's valid flag when no hazard exists.
- R2: A hazard exists when all of the following hold: both slots are valid, the reader's enabled read port has region code 2'b10 (global), the other slot's write is enabled with region 2'b10, and the two row numbers are equal. In the same cycle the reader's stall is 1 and its grant is 0, and the writer is granted. This holds for rows 0 and 2^ROW_W-1.
- R3: A region code of 2'b00 (private), 2'b01 (clause-temporary) or 2'b11 (reserved) on either the read or the write never causes a stall.
- R4: There is no hazard in any of these cases: the rows differ, the read port's enable is 0, either slot is invalid, or a slot reads its own write.
- R5: If each slot reads a global row that the other slot writes, only the odd slot is stalled and the even slot is granted.
- R6: A stall stays high for exactly `HOLD_CYC` consecutive cycles. In the next cycle the held slot is granted with its stall at 0, even if the other slot still writes the same row.
- R7: While a slot is held, the other slot is never stalled and its grant follows its valid flag.
- R8: In a reissue cycle, the slot that was not held is stalled if it reads a global row that the reissued slot writes. This starts a new hold for it.
- R9: A grant is never high together with its stall, and a grant is never high while its slot is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Even slot presents a group |
| ev_rd_en | input | NRD | Even read port enables |
| ev_rd_row | input | NRD x ROW_W | Even read rows |
| ev_rd_reg | input | NRD x 2 | Even read region codes |
| ev_wr_en | input | 1 | Even write enable |
| ev_wr_row | input | ROW_W | Even write row |
| ev_wr_reg | input | 2 | Even write region code |
| od_valid | input | 1 | Odd slot presents a group |
| od_rd_en | input | NRD | Odd read port enables |
| od_rd_row | input | NRD x ROW_W | Odd read rows |
| od_rd_reg | input | NRD x 2 | Odd read region codes |
| od_wr_en | input | 1 | Odd write enable |
| od_wr_row | input | ROW_W | Odd write row |
| od_wr_reg | input | 2 | Odd write region code |
| ev_stall | output | 1 | Even slot held |
| od_stall | output | 1 | Odd slot held |
| ev_grant | output | 1 | Even slot issues |
| od_grant | output | 1 | Odd slot issues |

## Verification
A wrong state or a wrong hold count shows at the ports within one instruction period. The symptoms are:
- a stall run that is shorter or longer than `HOLD_CYC`;
- a missing grant on the reissue cycle;
- a repeated stall against the write the slot has already waited for.

A wrong exemption or a wrong priority appears on the very cycle of the hazard: the wrong slot is stalled, or both slots are. The hold-then-reissue chain between the two slots exposes a held slot that is mixed up with the other slot within two periods.

// File: rtl/glreg_pkg.sv
package glreg_pkg;

    // Region tag carried with every translated row
    typedef enum logic [1:0] {
        REG_PRIV = 2'b00,
        REG_CTMP = 2'b01,
        REG_GLOB = 2'b10,
        REG_RSVD = 2'b11
    } region_t;

    // Controller states
    typedef enum logic [2:0] {
        ST_ISSUE    = 3'd0,
        ST_HOLD_EV  = 3'd1,
        ST_HOLD_OD  = 3'd2,
        ST_REISS_EV = 3'd3,
        ST_REISS_OD = 3'd4
    } hz_state_t;

endpackage

// File: rtl/glreg_hz_detect.sv
// One direction of the check: reads of one slot against the write of the other.
module glreg_hz_detect
    import glreg_pkg::*;
#(
    parameter int NRD   = 2,
    parameter int ROW_W = 7
) (
    input  logic                          rd_valid,
    input  logic [NRD-1:0]                rd_en,
    input  logic [NRD-1:0][ROW_W-1:0]     rd_row,
    input  logic [NRD-1:0][1:0]           rd_reg,
    input  logic                          wr_valid,
    input  logic                          wr_en,
    input  logic [ROW_W-1:0]              wr_row,
    input  logic [1:0]                    wr_reg,
    output logic                          hit
);

    logic [NRD-1:0] port_match;
    logic           wr_global;

    assign wr_global = wr_valid && wr_en && (wr_reg == REG_GLOB);

    for (genvar g = 0; g < NRD; g++) begin : g_port
        assign port_match[g] = rd_en[g] && (rd_reg[g] == REG_GLOB)
                               && (rd_row[g] == wr_row);
    end

    assign hit = rd_valid && wr_global && (|port_match);

endmodule

// File: rtl/glreg_hz_fsm.sv
// Hold / reissue controller. Index 0 is the even slot, index 1 the odd slot.
module glreg_hz_fsm
    import glreg_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] valid,
    input  logic [1:0] hit,
    output logic [1:0] stall,
    output logic [1:0] grant
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    hz_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [1:0]     eff_hit;
    logic [1:0]     new_stall;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ISSUE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // hazards that count in the current state (a reissued slot is exempt)
    always_comb begin
        eff_hit = '0;
        unique case (state_q)
            ST_ISSUE:    eff_hit = hit;
            ST_REISS_EV: eff_hit = {hit[1], 1'b0};
            ST_REISS_OD: eff_hit = {1'b0, hit[0]};
            default:     eff_hit = '0;
        endcase
        // odd wins the stall when both directions conflict
        if (eff_hit[1])      new_stall = 2'b10;
        else if (eff_hit[0]) new_stall = 2'b01;
        else                 new_stall = 2'b00;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ISSUE, ST_REISS_EV, ST_REISS_OD: begin
                if (new_stall[1]) begin
                    state_d = (HOLD_CYC == 1) ? ST_REISS_OD : ST_HOLD_OD;
                    cnt_d   = CW'(HOLD_CYC - 1);
                end else if (new_stall[0]) begin
                    state_d = (HOLD_CYC == 1) ? ST_REISS_EV : ST_HOLD_EV;
                    cnt_d   = CW'(HOLD_CYC - 1);
                end else begin
                    state_d = ST_ISSUE;
                end
            end
            ST_HOLD_EV: begin
                if (cnt_q == CW'(1)) state_d = ST_REISS_EV;
                cnt_d = cnt_q - CW'(1);
            end
            ST_HOLD_OD: begin
                if (cnt_q == CW'(1)) state_d = ST_REISS_OD;
                cnt_d = cnt_q - CW'(1);
            end
            default: begin
                state_d = ST_ISSUE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        stall = '0;
        unique case (state_q)
            ST_HOLD_EV: stall = 2'b01;
            ST_HOLD_OD: stall = 2'b10;
            default:    stall = new_stall;
        endcase
        grant = valid & ~stall;
        if (!rst_n) begin
            stall = '0;
            grant = '0;
        end
    end

endmodule

// File: rtl/glreg_hazard_unit.sv
module glreg_hazard_unit
    import glreg_pkg::*;
#(
    parameter int NRD      = 2,
    parameter int ROW_W    = 7,
    parameter int HOLD_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_valid,
    input  logic [NRD-1:0]            ev_rd_en,
    input  logic [NRD-1:0][ROW_W-1:0] ev_rd_row,
    input  logic [NRD-1:0][1:0]       ev_rd_reg,
    input  logic                      ev_wr_en,
    input  logic [ROW_W-1:0]          ev_wr_row,
    input  logic [1:0]                ev_wr_reg,
    input  logic                      od_valid,
    input  logic [NRD-1:0]            od_rd_en,
    input  logic [NRD-1:0][ROW_W-1:0] od_rd_row,
    input  logic [NRD-1:0][1:0]       od_rd_reg,
    input  logic                      od_wr_en,
    input  logic [ROW_W-1:0]          od_wr_row,
    input  logic [1:0]                od_wr_reg,
    output logic                      ev_stall,
    output logic                      od_stall,
    output logic                      ev_grant,
    output logic                      od_grant
);

    localparam int NSLOT = 2;

    logic [NSLOT-1:0]                      s_valid;
    logic [NSLOT-1:0][NRD-1:0]             s_rd_en;
    logic [NSLOT-1:0][NRD-1:0][ROW_W-1:0]  s_rd_row;
    logic [NSLOT-1:0][NRD-1:0][1:0]        s_rd_reg;
    logic [NSLOT-1:0]                      s_wr_en;
    logic [NSLOT-1:0][ROW_W-1:0]           s_wr_row;
    logic [NSLOT-1:0][1:0]                 s_wr_reg;
    logic [NSLOT-1:0]                      s_hit;
    logic [NSLOT-1:0]                      s_stall;
    logic [NSLOT-1:0]                      s_grant;

    assign s_valid  = {od_valid, ev_valid};
    assign s_rd_en  = {od_rd_en, ev_rd_en};
    assign s_rd_row = {od_rd_row, ev_rd_row};
    assign s_rd_reg = {od_rd_reg, ev_rd_reg};
    assign s_wr_en  = {od_wr_en, ev_wr_en};
    assign s_wr_row = {od_wr_row, ev_wr_row};
    assign s_wr_reg = {od_wr_reg, ev_wr_reg};

    // each slot's reads checked against the other slot's write
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        glreg_hz_detect #(.NRD(NRD), .ROW_W(ROW_W)) u_det (
            .rd_valid (s_valid[s]),
            .rd_en    (s_rd_en[s]),
            .rd_row   (s_rd_row[s]),
            .rd_reg   (s_rd_reg[s]),
            .wr_valid (s_valid[NSLOT-1-s]),
            .wr_en    (s_wr_en[NSLOT-1-s]),
            .wr_row   (s_wr_row[NSLOT-1-s]),
            .wr_reg   (s_wr_reg[NSLOT-1-s]),
            .hit      (s_hit[s])
        );
    end

    glreg_hz_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (s_valid),
        .hit   (s_hit),
        .stall (s_stall),
        .grant (s_grant)
    );

    assign ev_stall = s_stall[0];
    assign od_stall = s_stall[1];
    assign ev_grant = s_grant[0];
    assign od_grant = s_grant[1];

endmodule

// File: rtl/glreg_hazard_chk.sv
module glreg_hazard_chk #(
    parameter int HOLD_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ev_valid,
    input logic od_valid,
    input logic ev_stall,
    input logic od_stall,
    input logic ev_grant,
    input logic od_grant
);

    localparam int RW = $clog2(HOLD_CYC + 2);

    logic [RW-1:0] run_ev, run_od;

    // length of the current stall run per slot (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_ev <= '0;
            run_od <= '0;
        end else begin
            if (!ev_stall)                    run_ev <= '0;
            else if (run_ev != RW'(HOLD_CYC + 1)) run_ev <= run_ev + RW'(1);
            if (!od_stall)                    run_od <= '0;
            else if (run_od != RW'(HOLD_CYC + 1)) run_od <= run_od + RW'(1);
        end
    end

    assert_grant_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_grant && ev_stall) && !(od_grant && od_stall));

    assert_grant_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_grant |-> ev_valid) and (od_grant |-> od_valid));

    assert_one_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ev_stall, od_stall}) <= 1);

    assert_run_max_ev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_ev <= RW'(HOLD_CYC));

    assert_run_max_od_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_od <= RW'(HOLD_CYC));

    assert_run_exact_ev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_stall && run_ev != '0) |-> run_ev == RW'(HOLD_CYC));

    assert_run_exact_od_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!od_stall && run_od != '0) |-> run_od == RW'(HOLD_CYC));

    assert_reissue_ev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ev_stall) && ev_valid) |-> ev_grant);

    assert_reissue_od_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(od_stall) && od_valid) |-> od_grant);

endmodule

bind glreg_hazard_unit glreg_hazard_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .od_valid (od_valid),
    .ev_stall (ev_stall),
    .od_stall (od_stall),
    .ev_grant (ev_grant),
    .od_grant (od_grant)
);

// File: tb/sim_glreg_hazard_unit.sv
module sim_glreg_hazard_unit;

    localparam int NRD      = 2;
    localparam int ROW_W    = 7;
    localparam int HOLD_CYC = 2;

    localparam logic [1:0] PRV = 2'b00;
    localparam logic [1:0] CTM = 2'b01;
    localparam logic [1:0] GLB = 2'b10;
    localparam logic [1:0] RSV = 2'b11;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic                      ev_valid, od_valid;
    logic [NRD-1:0]            ev_rd_en, od_rd_en;
    logic [NRD-1:0][ROW_W-1:0] ev_rd_row, od_rd_row;
    logic [NRD-1:0][1:0]       ev_rd_reg, od_rd_reg;
    logic                      ev_wr_en, od_wr_en;
    logic [ROW_W-1:0]          ev_wr_row, od_wr_row;
    logic [1:0]                ev_wr_reg, od_wr_reg;
    logic                      ev_stall, od_stall, ev_grant, od_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0] exp;   // {ev_stall, od_stall, ev_grant, od_grant}
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    glreg_hazard_unit #(.NRD(NRD), .ROW_W(ROW_W), .HOLD_CYC(HOLD_CYC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_rd_en(ev_rd_en), .ev_rd_row(ev_rd_row),
        .ev_rd_reg(ev_rd_reg), .ev_wr_en(ev_wr_en), .ev_wr_row(ev_wr_row),
        .ev_wr_reg(ev_wr_reg),
        .od_valid(od_valid), .od_rd_en(od_rd_en), .od_rd_row(od_rd_row),
        .od_rd_reg(od_rd_reg), .od_wr_en(od_wr_en), .od_wr_row(od_wr_row),
        .od_wr_reg(od_wr_reg),
        .ev_stall(ev_stall), .od_stall(od_stall),
        .ev_grant(ev_grant), .od_grant(od_grant)
    );

    // monitor: compare mid-way between the driving edge and the active edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() != 0) begin
                item_t it;
                logic [3:0] act;
                it  = sb_q.pop_front();
                act = {ev_stall, od_stall, ev_grant, od_grant};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic clr();
        ev_valid = 1'b1; od_valid = 1'b1;
        ev_rd_en = '0; od_rd_en = '0;
        ev_rd_row = '0; od_rd_row = '0;
        ev_rd_reg = '0; od_rd_reg = '0;
        ev_wr_en = 1'b0; od_wr_en = 1'b0;
        ev_wr_row = '0; od_wr_row = '0;
        ev_wr_reg = PRV; od_wr_reg = PRV;
    endtask

    // driver: inputs are already set; push expectation and advance one cycle
    task automatic step(input logic [3:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // odd reads row r (port p, region rr) while even writes row r (region wr)
    task automatic set_od_reads_ev(input int p, input logic [ROW_W-1:0] r,
                                   input logic [1:0] rr, input logic [1:0] wr);
        od_rd_en[p] = 1'b1; od_rd_row[p] = r; od_rd_reg[p] = rr;
        ev_wr_en = 1'b1; ev_wr_row = r; ev_wr_reg = wr;
    endtask

    task automatic set_ev_reads_od(input int p, input logic [ROW_W-1:0] r,
                                   input logic [1:0] rr, input logic [1:0] wr);
        ev_rd_en[p] = 1'b1; ev_rd_row[p] = r; ev_rd_reg[p] = rr;
        od_wr_en = 1'b1; od_wr_row = r; od_wr_reg = wr;
    endtask

    initial begin
        clr();
        rst_n = 1'b0;
        @(negedge clk);
        step(4'b0000, "R1 outputs low in reset");
        step(4'b0000, "R1 outputs low in reset, second cycle");
        rst_n = 1'b1;
        step(4'b0011, "R1 idle grants follow valid");

        // R2: odd reads even's global write
        set_od_reads_ev(1, 7'd5, GLB, GLB);
        step(4'b0110, "R2 odd reader stalled, even granted");
        step(4'b0110, "R6 hold continues");
        step(4'b0011, "R6 reissue exempt from same write");
        clr();
        step(4'b0011, "R6 back to issue");

        // R3: non-global regions
        set_od_reads_ev(1, 7'd5, CTM, CTM);
        step(4'b0011, "R3 clause-temp both sides");
        clr(); set_od_reads_ev(0, 7'd5, PRV, PRV);
        step(4'b0011, "R3 private both sides");
        clr(); set_od_reads_ev(0, 7'd5, GLB, CTM);
        step(4'b0011, "R3 global read vs clause-temp write");
        clr(); set_od_reads_ev(0, 7'd5, CTM, GLB);
        step(4'b0011, "R3 clause-temp read vs global write");
        clr(); set_od_reads_ev(0, 7'd5, RSV, RSV);
        step(4'b0011, "R3 reserved code");

        // R4: no-hazard cases
        clr(); set_od_reads_ev(0, 7'd5, GLB, GLB); ev_wr_row = 7'd6;
        step(4'b0011, "R4 rows differ");
        clr(); set_od_reads_ev(0, 7'd5, GLB, GLB); od_rd_en = '0;
        step(4'b0011, "R4 read port disabled");
        clr(); set_od_reads_ev(0, 7'd5, GLB, GLB); ev_valid = 1'b0;
        step(4'b0001, "R4 writer slot invalid");
        clr(); set_od_reads_ev(0, 7'd5, GLB, GLB); od_valid = 1'b0;
        step(4'b0010, "R4 reader slot invalid");
        clr(); od_rd_en[0] = 1'b1; od_rd_row[0] = 7'd5; od_rd_reg[0] = GLB;
        od_wr_en = 1'b1; od_wr_row = 7'd5; od_wr_reg = GLB;
        step(4'b0011, "R4 own write not a hazard");

        // R2 even side
        clr(); set_ev_reads_od(0, 7'd3, GLB, GLB);
        step(4'b1001, "R2 even reader stalled, odd granted");
        step(4'b1001, "R6 even hold continues");
        step(4'b0011, "R6 even reissued");
        clr();
        step(4'b0011, "R6 issue after even reissue");

        // R2 row boundaries
        set_od_reads_ev(1, 7'd127, GLB, GLB);
        step(4'b0110, "R2 top row match");
        step(4'b0110, "R6 top row hold");
        step(4'b0011, "R6 top row reissue");
        clr(); set_ev_reads_od(0, 7'd0, GLB, GLB);
        step(4'b1001, "R2 row zero match");
        step(4'b1001, "R6 row zero hold");
        step(4'b0011, "R6 row zero reissue");

        // R5, R7, R8: cross hazard and chain
        clr();
        set_ev_reads_od(0, 7'd9, GLB, GLB);
        set_od_reads_ev(0, 7'd5, GLB, GLB);
        step(4'b0110, "R5 both directions stall odd only");
        step(4'b0110, "R7 even free while odd held");
        step(4'b1001, "R8 even stalled on reissued odd write");
        step(4'b1001, "R7 odd free while even held");
        od_rd_en = '0;
        step(4'b0011, "R6 even reissued after chain");
        clr();
        step(4'b0011, "R8 chain settles");

        // R7: other slot grant follows valid during hold
        set_od_reads_ev(0, 7'd12, GLB, GLB);
        step(4'b0110, "R2 stall before valid drop");
        ev_valid = 1'b0;
        step(4'b0100, "R7 other grant follows valid in hold");
        ev_valid = 1'b1;
        step(4'b0011, "R6 reissue after valid drop");
        clr();
        step(4'b0011, "R7 issue resumes");

        // R1: reset in the middle of a hold
        set_od_reads_ev(0, 7'd40, GLB, GLB);
        step(4'b0110, "R2 stall before reset");
        rst_n = 1'b0;
        step(4'b0000, "R1 reset during hold");
        rst_n = 1'b1; clr();
        step(4'b0011, "R1 issue after mid-hold reset");
        step(4'b0011, "R1 stays idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule